// File: doc/BRIEF.md
# Private Interrupt Configuration Register Bank

This block holds the configuration and state registers for the 32 private interrupts of a single processor. Interrupts 0 to 15 are software-generated and 16 to 31 are peripheral. Software reaches the bank over a simple single-cycle request port. Every request carries a secure/non-secure attribute, and a global security-disable input sets whether that attribute matters.

When security is enabled, a non-secure requester may only see and change the interrupts that its group bits grant. For the priority of a non-secure interrupt, that requester sees a view shifted by one bit position. The bank exposes the following:

- set/clear pairs for enable, pending and active
- a group word and a group-modifier word
- a non-secure access-control word
- a byte-addressable priority array
- two trigger-configuration words
- a wake word with a sleep handshake

A request sampled at a rising edge is answered in the next cycle. A small state machine drives the response: ST_IDLE, ST_ACK or ST_FAULT. Each cycle it moves to ST_FAULT if the current request cannot be decoded, to ST_ACK if it can, and to ST_IDLE if there is no request.

Top module: `pirq_cfg_bank`

## Requirements
- R1: After reset, all of the following are zero: the enable, pending, active, group, group-modifier, access-control and edge bitmaps, every priority byte, and the wake word. `rsp_valid` is low.
- R2: A request sampled at a rising edge gives `rsp_valid` high for exactly the following cycle. With no request, `rsp_valid` is low in the following cycle. The state names are ST_IDLE, ST_ACK and ST_FAULT, and the transitions are: no request to ST_IDLE, good request to ST_ACK, bad request to ST_FAULT.
- R3: The per-interrupt access mask depends on the access type and the security mode.
  - For a non-secure access (`req_secure`=0) while `sec_disable`=0, the mask equals the group word, so bits of group-0 interrupts read 0 and ignore writes.
  - In every other case the mask is all ones.
- R4: The set/clear pairs are enable (0x10 set, 0x14 clear), pending (0x18/0x1C) and active (0x20/0x24).
  - A set write ORs (data AND mask) into the bitmap.
  - A clear write clears the bits given by (data AND mask).
  - Both addresses of a pair read (bitmap AND mask).
- R5: A pending read returns (latch OR (`irq_level` AND NOT edge)) AND mask.
- R6: The priority view depends on the access.
  - For a non-secure access with security enabled to a group-1 interrupt, a read returns the stored byte shifted left by one, truncated to 8 bits.
  - A write from that access stores 0x80 OR (data shifted right by one).
  - For a group-0 interrupt, such an access reads 0 and its write is ignored.
  - Any other access reads and writes the byte unchanged.
- R7: Priorities occupy offsets 0x40 to 0x5F, one byte per interrupt.
  - A word access (`req_size`=2) must be 4-aligned. It covers four interrupts, with the lowest interrupt number in bits 7:0.
  - A byte access (`req_size`=0) covers one interrupt, with its data in bits 7:0.
- R8: The trigger words hold each edge flag in the odd bit 2k+1 of the interrupt's two-bit field.
  - Word 0x28 covers interrupts 0 to 15, is read-only, and reads the masked edge flags.
  - A write to word 0x2C sets the edge flag of interrupt 16+k from data bit 2k+1, where the mask allows.
  - A read of 0x2C returns the masked edge flags of interrupts 16 to 31.
- R9: The group word (0x04) reads 0 and ignores writes for a non-secure access while `sec_disable`=0. Otherwise it is fully readable and writable.
- R10: The group-modifier (0x08) and access-control (0x0C) words are readable and writable only when `req_secure`=1 and `sec_disable`=0. Otherwise they read 0 and ignore writes.
- R11: In the wake word (0x00), only bit 0 (sleep request) is writable. Bit 1 (children asleep) takes the same value on every write. All other bits read 0.
- R12: The following requests are errors: a byte access outside 0x40 to 0x5F, a misaligned word access, a word access to an unmapped offset, and `req_size` 1 or 3. An error raises `rsp_err` with `rsp_valid` for one cycle, returns `rsp_rdata`=0 and changes no state. Accepted writes also return `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_disable | input | 1 | 1 disables security filtering globally |
| irq_level | input | 32 | Live input level of each private interrupt |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 2 word, 1 and 3 unsupported |
| req_addr | input | 8 | Byte offset within the bank |
| req_wdata | input | 32 | Write data (bits 7:0 for byte access) |
| req_secure | input | 1 | 1 secure access, 0 non-secure |
| rsp_valid | output | 1 | Response cycle for the previous request |
| rsp_err | output | 1 | Previous request was undecodable |
| rsp_rdata | output | 32 | Read data for the previous request |

## Verification
The bench concentrates on cases where the security filter and the data path interact:
- A non-secure set write that spans both groups. If the mask were missing, the hidden group-0 bits would come back set.
- Priority writes that cross both groups in one word. If the shift were applied the wrong way, or applied to secure traffic, the secure read-back would be wrong.
- Level-triggered pending read-out under a changing `irq_level`. If the edge bit were not honoured, an edge interrupt's line would leak into the read.
- Writes to the read-only trigger word and undecodable requests. If either were handled wrongly, the enable bitmap or the edge flags would change where they must not.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int DATA_W = 32;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [7:0] OFS_WAKE   = 8'h00;
    localparam logic [7:0] OFS_GROUP  = 8'h04;
    localparam logic [7:0] OFS_GMOD   = 8'h08;
    localparam logic [7:0] OFS_NSAC   = 8'h0C;
    localparam logic [7:0] OFS_EN_S   = 8'h10;
    localparam logic [7:0] OFS_EN_C   = 8'h14;
    localparam logic [7:0] OFS_PD_S   = 8'h18;
    localparam logic [7:0] OFS_PD_C   = 8'h1C;
    localparam logic [7:0] OFS_AC_S   = 8'h20;
    localparam logic [7:0] OFS_AC_C   = 8'h24;
    localparam logic [7:0] OFS_CFG_LO = 8'h28;
    localparam logic [7:0] OFS_CFG_HI = 8'h2C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_WAKE,
        SEL_GROUP,
        SEL_GMOD,
        SEL_NSAC,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_PD_SET,
        SEL_PD_CLR,
        SEL_AC_SET,
        SEL_AC_CLR,
        SEL_CFG_LO,
        SEL_CFG_HI,
        SEL_PRIO
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACK,
        ST_FAULT
    } bus_state_e;

endpackage

// File: rtl/pirq_decode.sv
module pirq_decode
    import pirq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PRIO_BASE = 64,
    parameter int NUM_IRQ   = 32,
    parameter int LANES     = 4
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [1:0]                 size,
    output reg_sel_e                   sel,
    output logic                       err,
    output logic [$clog2(NUM_IRQ)-1:0] prio_first,
    output logic [LANES-1:0]           lane_en
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    logic in_prio;

    assign in_prio    = (32'(addr) >= PRIO_BASE) && (32'(addr) < PRIO_BASE + NUM_IRQ);
    assign prio_first = IDX_W'(32'(addr) - PRIO_BASE);

    always_comb begin
        sel     = SEL_NONE;
        lane_en = '0;
        if (size == SZ_BYTE) begin
            if (in_prio) begin
                sel        = SEL_PRIO;
                lane_en[0] = 1'b1;
            end
        end else if (size == SZ_WORD && addr[1:0] == 2'b00) begin
            if (in_prio) begin
                sel     = SEL_PRIO;
                lane_en = '1;
            end else begin
                case (addr)
                    ADDR_W'(OFS_WAKE):   sel = SEL_WAKE;
                    ADDR_W'(OFS_GROUP):  sel = SEL_GROUP;
                    ADDR_W'(OFS_GMOD):   sel = SEL_GMOD;
                    ADDR_W'(OFS_NSAC):   sel = SEL_NSAC;
                    ADDR_W'(OFS_EN_S):   sel = SEL_EN_SET;
                    ADDR_W'(OFS_EN_C):   sel = SEL_EN_CLR;
                    ADDR_W'(OFS_PD_S):   sel = SEL_PD_SET;
                    ADDR_W'(OFS_PD_C):   sel = SEL_PD_CLR;
                    ADDR_W'(OFS_AC_S):   sel = SEL_AC_SET;
                    ADDR_W'(OFS_AC_C):   sel = SEL_AC_CLR;
                    ADDR_W'(OFS_CFG_LO): sel = SEL_CFG_LO;
                    ADDR_W'(OFS_CFG_HI): sel = SEL_CFG_HI;
                    default:             sel = SEL_NONE;
                endcase
            end
        end
    end

    assign err = (sel == SEL_NONE);

endmodule

// File: rtl/pirq_access_mask.sv
module pirq_access_mask #(
    parameter int NUM_IRQ = 32
) (
    input  logic               secure,
    input  logic               sec_disable,
    input  logic [NUM_IRQ-1:0] group,
    output logic [NUM_IRQ-1:0] mask,
    output logic               ns_filtered,
    output logic               group_visible,
    output logic               secure_only_visible
);
    // Filtering applies only to non-secure traffic while security is on.
    assign ns_filtered         = !secure && !sec_disable;
    assign mask                = ns_filtered ? group : '1;
    assign group_visible       = !ns_filtered;
    assign secure_only_visible = secure && !sec_disable;

endmodule

// File: rtl/pirq_prio_lane.sv
module pirq_prio_lane #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] stored,
    input  logic              ns_filtered,
    input  logic              grp_bit,
    input  logic [PRIO_W-1:0] wr_in,
    output logic [PRIO_W-1:0] rd_byte,
    output logic              wr_ok,
    output logic [PRIO_W-1:0] wr_byte
);
    logic hidden;

    assign hidden  = ns_filtered && !grp_bit;
    assign rd_byte = hidden      ? '0 :
                     ns_filtered ? {stored[PRIO_W-2:0], 1'b0} : stored;
    assign wr_ok   = !hidden;
    assign wr_byte = ns_filtered ? {1'b1, wr_in[PRIO_W-1:1]} : wr_in;

endmodule

// File: rtl/pirq_cfg_bank.sv
module pirq_cfg_bank
    import pirq_pkg::*;
#(
    parameter int NUM_IRQ   = 32,
    parameter int NUM_SGI   = 16,
    parameter int ADDR_W    = 8,
    parameter int PRIO_W    = 8,
    parameter int PRIO_BASE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_disable,
    input  logic [NUM_IRQ-1:0] irq_level,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_secure,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int IDX_W  = $clog2(NUM_IRQ);
    localparam int LANES  = DATA_W / PRIO_W;
    localparam int NUM_PP = NUM_IRQ - NUM_SGI;

    // ---------------- state ----------------
    bus_state_e        state_q, state_d;
    logic [NUM_IRQ-1:0] en_q, pend_q, act_q, grp_q, gmod_q, nsac_q, edge_q;
    logic [NUM_IRQ-1:0] en_d, pend_d, act_d, grp_d, gmod_d, nsac_d, edge_d;
    logic [PRIO_W-1:0]  prio_q [NUM_IRQ];
    logic               sleep_q, asleep_q, sleep_d, asleep_d;
    logic [DATA_W-1:0]  rdata_q, rdata_d;

    // ---------------- decode and filter ----------------
    reg_sel_e           sel;
    logic               dec_err;
    logic [IDX_W-1:0]   prio_first;
    logic [LANES-1:0]   lane_en;
    logic [NUM_IRQ-1:0] mask;
    logic               ns_filt, grp_vis, sec_vis;
    logic               wr_fire;

    pirq_decode #(
        .ADDR_W   (ADDR_W),
        .PRIO_BASE(PRIO_BASE),
        .NUM_IRQ  (NUM_IRQ),
        .LANES    (LANES)
    ) u_dec (
        .addr      (req_addr),
        .size      (req_size),
        .sel       (sel),
        .err       (dec_err),
        .prio_first(prio_first),
        .lane_en   (lane_en)
    );

    pirq_access_mask #(.NUM_IRQ(NUM_IRQ)) u_mask (
        .secure             (req_secure),
        .sec_disable        (sec_disable),
        .group              (grp_q),
        .mask               (mask),
        .ns_filtered        (ns_filt),
        .group_visible      (grp_vis),
        .secure_only_visible(sec_vis)
    );

    assign wr_fire = req_valid && req_write && !dec_err;

    // ---------------- priority lanes ----------------
    logic [IDX_W-1:0]  lane_idx [LANES];
    logic [PRIO_W-1:0] lane_rd  [LANES];
    logic [PRIO_W-1:0] lane_wr  [LANES];
    logic [LANES-1:0]  lane_ok;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] prio_view;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_idx[l] = prio_first + IDX_W'(l);

        pirq_prio_lane #(.PRIO_W(PRIO_W)) u_lane (
            .stored     (prio_q[lane_idx[l]]),
            .ns_filtered(ns_filt),
            .grp_bit    (grp_q[lane_idx[l]]),
            .wr_in      (req_wdata[PRIO_W*l +: PRIO_W]),
            .rd_byte    (lane_rd[l]),
            .wr_ok      (lane_ok[l]),
            .wr_byte    (lane_wr[l])
        );

        assign lane_we[l] = wr_fire && (sel == SEL_PRIO) && lane_en[l] && lane_ok[l];
        assign prio_view[PRIO_W*l +: PRIO_W] = lane_en[l] ? lane_rd[l] : '0;
    end

    // ---------------- trigger-configuration views ----------------
    logic [DATA_W-1:0] cfg_lo_view, cfg_hi_view;
    logic [NUM_PP-1:0] cfg_odd;

    always_comb begin
        cfg_lo_view = '0;
        cfg_hi_view = '0;
        cfg_odd     = '0;
        for (int k = 0; k < NUM_SGI; k++) begin
            cfg_lo_view[2*k+1] = edge_q[k] & mask[k];
        end
        for (int k = 0; k < NUM_PP; k++) begin
            cfg_hi_view[2*k+1] = edge_q[NUM_SGI+k] & mask[NUM_SGI+k];
            cfg_odd[k]         = req_wdata[2*k+1];
        end
    end

    // ---------------- next state of the register file ----------------
    always_comb begin
        en_d     = en_q;
        pend_d   = pend_q;
        act_d    = act_q;
        grp_d    = grp_q;
        gmod_d   = gmod_q;
        nsac_d   = nsac_q;
        edge_d   = edge_q;
        sleep_d  = sleep_q;
        asleep_d = asleep_q;
        if (wr_fire) begin
            unique case (sel)
                SEL_WAKE: begin
                    sleep_d  = req_wdata[0];
                    asleep_d = req_wdata[0];
                end
                SEL_GROUP:  if (grp_vis) grp_d  = req_wdata;
                SEL_GMOD:   if (sec_vis) gmod_d = req_wdata;
                SEL_NSAC:   if (sec_vis) nsac_d = req_wdata;
                SEL_EN_SET: en_d   = en_q   |  (req_wdata & mask);
                SEL_EN_CLR: en_d   = en_q   & ~(req_wdata & mask);
                SEL_PD_SET: pend_d = pend_q |  (req_wdata & mask);
                SEL_PD_CLR: pend_d = pend_q & ~(req_wdata & mask);
                SEL_AC_SET: act_d  = act_q  |  (req_wdata & mask);
                SEL_AC_CLR: act_d  = act_q  & ~(req_wdata & mask);
                SEL_CFG_HI: begin
                    for (int k = 0; k < NUM_PP; k++) begin
                        if (mask[NUM_SGI+k]) edge_d[NUM_SGI+k] = cfg_odd[k];
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- read data ----------------
    always_comb begin
        rdata_d = '0;
        unique case (sel)
            SEL_WAKE:               rdata_d = {{(DATA_W-2){1'b0}}, asleep_q, sleep_q};
            SEL_GROUP:              rdata_d = grp_vis ? grp_q : '0;
            SEL_GMOD:               rdata_d = sec_vis ? gmod_q : '0;
            SEL_NSAC:               rdata_d = sec_vis ? nsac_q : '0;
            SEL_EN_SET, SEL_EN_CLR: rdata_d = en_q & mask;
            SEL_PD_SET, SEL_PD_CLR: rdata_d = (pend_q | (irq_level & ~edge_q)) & mask;
            SEL_AC_SET, SEL_AC_CLR: rdata_d = act_q & mask;
            SEL_CFG_LO:             rdata_d = cfg_lo_view;
            SEL_CFG_HI:             rdata_d = cfg_hi_view;
            SEL_PRIO:               rdata_d = prio_view;
            default:                rdata_d = '0;
        endcase
    end

    // ---------------- response state machine ----------------
    always_comb begin
        if (!req_valid)   state_d = ST_IDLE;
        else if (dec_err) state_d = ST_FAULT;
        else              state_d = ST_ACK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  begin rsp_valid = 1'b0; rsp_err = 1'b0; end
            ST_ACK:   begin rsp_valid = 1'b1; rsp_err = 1'b0; end
            ST_FAULT: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default:  begin rsp_valid = 1'b0; rsp_err = 1'b0; end
        endcase
    end

    assign rsp_rdata = rdata_q;

    // ---------------- registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            pend_q   <= '0;
            act_q    <= '0;
            grp_q    <= '0;
            gmod_q   <= '0;
            nsac_q   <= '0;
            edge_q   <= '0;
            sleep_q  <= 1'b0;
            asleep_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            en_q     <= en_d;
            pend_q   <= pend_d;
            act_q    <= act_d;
            grp_q    <= grp_d;
            gmod_q   <= gmod_d;
            nsac_q   <= nsac_d;
            edge_q   <= edge_d;
            sleep_q  <= sleep_d;
            asleep_q <= asleep_d;
            rdata_q  <= (req_valid && !req_write && !dec_err) ? rdata_d : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_IRQ; n++) prio_q[n] <= '0;
        end else begin
            for (int n = 0; n < NUM_IRQ; n++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (lane_we[l] && lane_idx[l] == IDX_W'(n)) prio_q[n] <= lane_wr[l];
                end
            end
        end
    end

endmodule

// File: rtl/pirq_cfg_bank_chk.sv
module pirq_cfg_bank_chk
    import pirq_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sec_disable,
    input logic               req_valid,
    input logic               req_write,
    input logic [1:0]         req_size,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               req_secure,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic [NUM_IRQ-1:0] en_q,
    input logic [NUM_IRQ-1:0] pend_q,
    input logic [NUM_IRQ-1:0] act_q,
    input logic [NUM_IRQ-1:0] grp_q
);
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r12_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    a_r12_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (en_q == $past(en_q) && pend_q == $past(pend_q) &&
                     act_q == $past(act_q) && grp_q == $past(grp_q)));

    a_r9_group_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_valid && !req_write && req_size == SZ_WORD &&
                            req_addr == ADDR_W'(OFS_GROUP) && !req_secure && !sec_disable))
        |-> rsp_rdata == '0);

    a_r11_wake_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && $past(req_valid && !req_write && req_size == SZ_WORD &&
                                        req_addr == ADDR_W'(OFS_WAKE)))
        |-> rsp_rdata[1] == rsp_rdata[0]);

endmodule

bind pirq_cfg_bank pirq_cfg_bank_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_disable(sec_disable),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .req_secure (req_secure),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .en_q       (en_q),
    .pend_q     (pend_q),
    .act_q      (act_q),
    .grp_q      (grp_q)
);

// File: tb/sim_pirq_cfg_bank.sv
module sim_pirq_cfg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_disable = 1'b0;
    logic [31:0] irq_level = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_secure = 1'b1;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pirq_cfg_bank u0 (
        .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .irq_level(irq_level),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    // -------- bench model built from the requirements --------
    logic [31:0] m_en = '0, m_pend = '0, m_act = '0, m_grp = '0;
    logic [31:0] m_gmod = '0, m_nsac = '0, m_edge = '0;
    logic [7:0]  m_prio [32];
    logic        m_sleep = 1'b0;

    function automatic logic ns_on(input logic sec);
        return !sec && !sec_disable;
    endfunction

    function automatic logic [31:0] f_mask(input logic sec);
        return ns_on(sec) ? m_grp : 32'hFFFF_FFFF;
    endfunction

    function automatic logic f_err(input logic [1:0] sz, input logic [7:0] a);
        logic in_p;
        in_p = (a >= 8'h40) && (a < 8'h60);
        if (sz == 2'd0) return !in_p;
        if (sz != 2'd2) return 1'b1;
        if (a[1:0] != 2'b00) return 1'b1;
        if (in_p) return 1'b0;
        return (a > 8'h2C);
    endfunction

    function automatic logic [7:0] f_prd(input int n, input logic sec);
        if (ns_on(sec)) return m_grp[n] ? {m_prio[n][6:0], 1'b0} : 8'h00;
        return m_prio[n];
    endfunction

    function automatic logic [31:0] f_rd(input logic [1:0] sz, input logic [7:0] a, input logic sec);
        logic [31:0] r, mk;
        int b;
        mk = f_mask(sec);
        r  = '0;
        if (a >= 8'h40) begin
            b = int'(a) - 64;
            if (sz == 2'd0) r = {24'h0, f_prd(b, sec)};
            else r = {f_prd(b+3, sec), f_prd(b+2, sec), f_prd(b+1, sec), f_prd(b, sec)};
        end else begin
            case (a)
                8'h00: r = {30'h0, m_sleep, m_sleep};
                8'h04: r = ns_on(sec) ? 32'h0 : m_grp;
                8'h08: r = (sec && !sec_disable) ? m_gmod : 32'h0;
                8'h0C: r = (sec && !sec_disable) ? m_nsac : 32'h0;
                8'h10, 8'h14: r = m_en & mk;
                8'h18, 8'h1C: r = (m_pend | (irq_level & ~m_edge)) & mk;
                8'h20, 8'h24: r = m_act & mk;
                8'h28: for (int k = 0; k < 16; k++) r[2*k+1] = m_edge[k] & mk[k];
                8'h2C: for (int k = 0; k < 16; k++) r[2*k+1] = m_edge[16+k] & mk[16+k];
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    task automatic prio_wr(input int n, input logic [7:0] v, input logic sec);
        if (ns_on(sec)) begin
            if (m_grp[n]) m_prio[n] = {1'b1, v[7:1]};
        end else begin
            m_prio[n] = v;
        end
    endtask

    task automatic model_wr(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d, input logic sec);
        logic [31:0] mk;
        int b;
        mk = f_mask(sec);
        if (a >= 8'h40) begin
            b = int'(a) - 64;
            if (sz == 2'd0) prio_wr(b, d[7:0], sec);
            else for (int l = 0; l < 4; l++) prio_wr(b+l, d[8*l +: 8], sec);
        end else begin
            case (a)
                8'h00: m_sleep = d[0];
                8'h04: if (!ns_on(sec)) m_grp = d;
                8'h08: if (sec && !sec_disable) m_gmod = d;
                8'h0C: if (sec && !sec_disable) m_nsac = d;
                8'h10: m_en   = m_en   |  (d & mk);
                8'h14: m_en   = m_en   & ~(d & mk);
                8'h18: m_pend = m_pend |  (d & mk);
                8'h1C: m_pend = m_pend & ~(d & mk);
                8'h20: m_act  = m_act  |  (d & mk);
                8'h24: m_act  = m_act  & ~(d & mk);
                8'h2C: for (int k = 0; k < 16; k++) if (mk[16+k]) m_edge[16+k] = d[2*k+1];
                default: ;
            endcase
        end
    endtask

    // One request, checked one cycle later. Called at a falling edge.
    task automatic acc(input logic wr, input logic [1:0] sz, input logic [7:0] a,
                       input logic [31:0] d, input logic sec, input string tag);
        logic        e_err;
        logic [31:0] e_rd;
        e_err = f_err(sz, a);
        e_rd  = (wr || e_err) ? 32'h0 : f_rd(sz, a, sec);
        req_valid  = 1'b1;
        req_write  = wr;
        req_size   = sz;
        req_addr   = a;
        req_wdata  = d;
        req_secure = sec;
        @(posedge clk);
        if (wr && !e_err) model_wr(sz, a, d, sec);
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_err !== e_err || rsp_rdata !== e_rd) begin
            fails++;
            $display("FAIL %s: addr=%h valid=%b err=%b rdata=%h expected valid=1 err=%b rdata=%h",
                     tag, a, rsp_valid, rsp_err, rsp_rdata, e_err, e_rd);
        end
    endtask

    task automatic expect_idle(input string tag);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s: rsp_valid=%b expected 0", tag, rsp_valid);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        logic [7:0] wa [12];
        wa = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C};
        for (int n = 0; n < 32; n++) m_prio[n] = 8'h00;
        seed_init = $urandom(32'd5501);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and idle response
        expect_idle("R1 idle after reset");
        acc(0, 2, 8'h10, 0, 1, "R1 enable reset");
        acc(0, 2, 8'h04, 0, 1, "R1 group reset");
        acc(0, 2, 8'h4C, 0, 1, "R1 priority reset");
        acc(0, 2, 8'h00, 0, 1, "R1 wake reset");
        expect_idle("R2 no request no response");
        // R4: set/clear pairs
        acc(1, 2, 8'h10, 32'h8000_F00F, 1, "R4 enable set");
        acc(0, 2, 8'h14, 0, 1, "R4 enable read via clear address");
        acc(1, 2, 8'h14, 32'h0000_000F, 1, "R4 enable clear");
        acc(0, 2, 8'h10, 0, 1, "R4 enable after clear");
        acc(1, 2, 8'h20, 32'h0000_0300, 1, "R4 active set");
        acc(0, 2, 8'h24, 0, 1, "R4 active read");
        // R9/R3: group and NS mask
        acc(1, 2, 8'h04, 32'hFFFF_0000, 1, "R9 secure group write");
        acc(1, 2, 8'h04, 32'h0000_FFFF, 0, "R9 NS group write ignored");
        acc(0, 2, 8'h04, 0, 0, "R9 NS group read zero");
        acc(0, 2, 8'h04, 0, 1, "R9 secure group unchanged");
        acc(1, 2, 8'h10, 32'hFFFF_FFFF, 0, "R3 NS enable set masked");
        acc(0, 2, 8'h10, 0, 1, "R3 secure sees only group1 set");
        acc(0, 2, 8'h10, 0, 0, "R3 NS read masked");
        sec_disable = 1'b1;
        acc(1, 2, 8'h14, 32'h0000_8000, 0, "R3 NS clear with security off");
        acc(0, 2, 8'h10, 0, 0, "R3 NS full view with security off");
        acc(0, 2, 8'h04, 0, 0, "R9 group visible with security off");
        sec_disable = 1'b0;
        // R6/R7: priorities
        acc(1, 2, 8'h50, 32'h4433_2211, 1, "R7 secure word priority write");
        acc(0, 2, 8'h50, 0, 1, "R7 little-endian read");
        acc(0, 2, 8'h50, 0, 0, "R6 NS shifted read");
        acc(1, 0, 8'h51, 32'h0000_0040, 0, "R6 NS byte write shifted");
        acc(0, 0, 8'h51, 0, 1, "R6 secure sees 0xA0");
        acc(1, 2, 8'h40, 32'hFFFF_FFFF, 0, "R6 NS write to group0 ignored");
        acc(0, 2, 8'h40, 0, 1, "R6 group0 priorities unchanged");
        acc(0, 0, 8'h52, 0, 0, "R7 byte read");
        acc(1, 2, 8'h5C, 32'hF1E2_D3C4, 1, "R7 last word");
        acc(0, 0, 8'h5F, 0, 1, "R7 last byte");
        // R8: trigger config
        acc(1, 2, 8'h2C, 32'hAAAA_5555, 1, "R8 high word write");
        acc(0, 2, 8'h2C, 0, 1, "R8 high word read");
        acc(1, 2, 8'h28, 32'hFFFF_FFFF, 1, "R8 low word read-only write");
        acc(0, 2, 8'h28, 0, 1, "R8 low word still zero");
        // R5: pending with levels (edge set on 24..31, clear on 16..23)
        irq_level = 32'h8101_0002;
        acc(0, 2, 8'h18, 0, 1, "R5 level-triggered lines visible");
        acc(1, 2, 8'h18, 32'h4000_0000, 1, "R5 pending set");
        acc(0, 2, 8'h1C, 0, 0, "R5 NS pending view");
        irq_level = 32'h0;
        acc(0, 2, 8'h18, 0, 1, "R5 latch only");
        // R10: secure-only registers
        acc(1, 2, 8'h08, 32'h1234_5678, 1, "R10 group modifier write");
        acc(0, 2, 8'h08, 0, 1, "R10 group modifier read");
        acc(0, 2, 8'h08, 0, 0, "R10 hidden from NS");
        acc(1, 2, 8'h0C, 32'hCAFE_0001, 0, "R10 NS write ignored");
        acc(0, 2, 8'h0C, 0, 1, "R10 access-control still zero");
        sec_disable = 1'b1;
        acc(0, 2, 8'h08, 0, 1, "R10 hidden when security off");
        sec_disable = 1'b0;
        // R11: wake
        acc(1, 2, 8'h00, 32'hFFFF_FFFF, 1, "R11 sleep set");
        acc(0, 2, 8'h00, 0, 1, "R11 both bits set");
        acc(1, 2, 8'h00, 32'hFFFF_FFFE, 0, "R11 sleep clear");
        acc(0, 2, 8'h00, 0, 0, "R11 both bits clear");
        // R12: errors
        acc(1, 2, 8'h30, 32'hFFFF_FFFF, 1, "R12 unmapped word");
        acc(1, 0, 8'h10, 32'hFFFF_FFFF, 1, "R12 byte outside priorities");
        acc(1, 2, 8'h42, 32'hFFFF_FFFF, 1, "R12 misaligned word");
        acc(1, 1, 8'h10, 32'hFFFF_FFFF, 1, "R12 size 1");
        acc(0, 3, 8'h40, 0, 1, "R12 size 3 read");
        acc(0, 2, 8'h10, 0, 1, "R12 enable unchanged after errors");
        acc(0, 2, 8'h40, 0, 1, "R12 priorities unchanged after errors");
        expect_idle("R2 idle after burst");
        // Random mix: R3 R4 R6 R7 R8
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            logic [1:0] sz;
            int pick;
            pick = int'($urandom_range(0, 9));
            sec_disable = ($urandom_range(0, 3) == 0);
            irq_level   = $urandom;
            if (pick < 5) begin
                a  = wa[$urandom_range(0, 11)];
                sz = 2'd2;
            end else if (pick < 8) begin
                sz = ($urandom_range(0, 1) == 0) ? 2'd0 : 2'd2;
                a  = 8'h40 + 8'($urandom_range(0, 31));
                if (sz == 2'd2) a[1:0] = 2'b00;
            end else begin
                a  = 8'($urandom_range(0, 255));
                sz = 2'($urandom_range(0, 3));
            end
            acc($urandom_range(0, 1) == 1, sz, a, $urandom, $urandom_range(0, 1) == 1,
                "R3 R4 R6 R7 R8 random access");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule